// File: doc/BRIEF.md
# Multi-Level Interrupt Mask Controller

This block gathers the external interrupt sources of one processor core into four priority levels of 32 sources each. For every level it keeps a registered copy of the source lines, called the pending status, and a mask word in which a 1 disables a source. Each level drives one request line toward the core. That line is high whenever some source is pending and its mask bit is 0.

Software changes a mask only by writing ones. A write to a level's set register disables the named sources. A write to its clear register enables them. The current mask and the pending status can be read back. The register port is a request/response stream:

- A request moves when `req_valid` and `req_ready` are both high on a clock edge. Every accepted request, read or write, returns exactly one response beat one cycle later.
- While a response beat waits with `rsp_ready` low, it stays unchanged and `req_ready` is held low. This stalls new requests.
- `req_ready` is high whenever no response is waiting, or when the waiting one leaves in the same cycle.

Level n starts at byte address 16·n. Inside each level the registers sit in this order: set (+0), clear (+4), mask (+8), status (+12). The source inputs arrive as one flat vector, with level n's sources in bits [32·n+31 : 32·n].

Top module: `intr_mask_ctrl`

## Requirements
- R1: After reset every mask bit of every level is 1, every request line is 0 and no response beat is waiting.
- R2: Writing to a level's set register (offset +0) makes each mask bit whose write bit is 1 equal to 1. Mask bits whose write bit is 0 keep their value.
- R3: Writing to a level's clear register (offset +4) makes each mask bit whose write bit is 1 equal to 0. Mask bits whose write bit is 0 keep their value.
- R4: A level's status register (offset +12) reads the value its 32 source inputs had one clock edge earlier, so a source change reaches the status one cycle later.
- R5: Request line n is high exactly when some bit of level n's status is 1 while the same mask bit is 0.
- R6: Level n occupies bytes 16·n to 16·n+15, and an access to one level leaves the masks and request lines of the other levels unchanged.
- R7: Reads of the set and clear registers return zero. Writes to the mask (+8) and status (+12) registers change nothing.
- R8: On level 0 the inter-core doorbell source is bit 8. Writing 0x10 to level 0's clear register enables only bit 4 and leaves bit 8 masked. Writing 0x100 to it enables the doorbell.
- R9: Each accepted request yields exactly one response beat. A write's beat carries zero data. A stalled beat holds its data, and `req_ready` stays low while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl_i | input | 128 | Level-sensitive sources, level n in bits [32n+31:32n] |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address: level in [5:4], register in [3:2] |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Response beat can be taken |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| irq_o | output | 4 | Request line per level |

## Verification
The bench hits the doorbell trap first. It writes 0x10 and then 0x100 to level 0's clear register while only source 8 is active. A design that decodes bit numbers wrongly, or that treats a clear write as a plain store, would raise the level 0 request too early, or would wipe the mask bits the write does not name. Set, clear and read-only accesses are aimed at one level while the other levels are read back, so a wrong level decode shows up as a disturbed mask. Writes to the mask and status registers would show up as a mask that changes. The bench also drives sources that match only masked bits, and it checks the request line in the cycle before and the cycle after a source edge, which catches a missing or extra register stage. Finally it stalls the response for several cycles to catch a beat that is dropped, repeated or changed while waiting.

// File: rtl/imc_pkg.sv
package imc_pkg;
  // register slot inside one level; order is part of the address map
  typedef enum logic [1:0] {
    SLOT_SET  = 2'd0,
    SLOT_CLR  = 2'd1,
    SLOT_MASK = 2'd2,
    SLOT_STAT = 2'd3
  } imc_slot_e;

  localparam int SLOT_BYTES  = 4;
  localparam int LEVEL_BYTES = 16;
  localparam int SLOT_LSB    = 2;
  localparam int LEVEL_LSB   = 4;
endpackage

// File: rtl/imc_level.sv
module imc_level #(
  parameter int SRC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] mask_o,
  output logic [SRC_W-1:0] stat_o,
  output logic             irq_o
);
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] stat_q;

  // sources are level sensitive: status is a one-stage copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= src_i;
    end
  end

  // mask only moves through write-one-to-set / write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (set_we_i) begin
      mask_q <= mask_q | wdata_i;
    end else if (clr_we_i) begin
      mask_q <= mask_q & ~wdata_i;
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ~mask_q);

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_we_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !set_we_i) |=> ((mask_q & $past(wdata_i)) == '0)); // R3
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we_i && !clr_we_i) |=> $stable(mask_q)); // R7
  AST_STAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (stat_q == $past(src_i))); // R4
endmodule

// File: rtl/imc_regbus.sv
module imc_regbus
  import imc_pkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid_i,
  output logic                            req_ready_o,
  input  logic                            req_write_i,
  input  logic [ADDR_W-1:0]               req_addr_i,
  input  logic [DATA_W-1:0]               req_wdata_i,
  output logic                            rsp_valid_o,
  input  logic                            rsp_ready_i,
  output logic [DATA_W-1:0]               rsp_rdata_o,
  input  logic [NUM_LVL-1:0][DATA_W-1:0]  lvl_mask_i,
  input  logic [NUM_LVL-1:0][DATA_W-1:0]  lvl_stat_i,
  output logic [NUM_LVL-1:0]              set_we_o,
  output logic [NUM_LVL-1:0]              clr_we_o,
  output logic [DATA_W-1:0]               wdata_o
);
  localparam int LVL_IDX_W = ADDR_W - LEVEL_LSB;

  logic                 rsp_valid_q;
  logic [DATA_W-1:0]    rsp_data_q;
  logic                 accept;
  imc_slot_e            slot;
  logic [LVL_IDX_W-1:0] lvl_idx;
  logic                 lvl_ok;
  logic [DATA_W-1:0]    rd_word;

  assign req_ready_o = !rsp_valid_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;
  assign slot        = imc_slot_e'(req_addr_i[LEVEL_LSB-1:SLOT_LSB]);
  assign lvl_idx     = req_addr_i[ADDR_W-1:LEVEL_LSB];
  assign lvl_ok      = (int'(lvl_idx) < NUM_LVL);
  assign wdata_o     = req_wdata_i;

  // one write strobe per level and slot kind
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_dec
    logic hit;
    assign hit         = accept && req_write_i && (int'(lvl_idx) == g);
    assign set_we_o[g] = hit && (slot == SLOT_SET);
    assign clr_we_o[g] = hit && (slot == SLOT_CLR);
  end

  always_comb begin
    rd_word = '0;
    if (lvl_ok) begin
      unique case (slot)
        SLOT_MASK: rd_word = lvl_mask_i[lvl_idx];
        SLOT_STAT: rd_word = lvl_stat_i[lvl_idx];
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= req_write_i ? '0 : rd_word;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_q && !rsp_ready_i) |=> (rsp_valid_q && $stable(rsp_data_q))); // R9
  AST_ACCEPT_GIVES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid_q); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_we_o, clr_we_o})); // R6
endmodule

// File: rtl/intr_mask_ctrl.sv
module intr_mask_ctrl #(
  parameter int NUM_LVL = 4,
  parameter int SRC_W   = 32,
  localparam int LVL_BITS = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
  localparam int ADDR_W   = LVL_BITS + imc_pkg::LEVEL_LSB
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_LVL*SRC_W-1:0] src_lvl_i,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [SRC_W-1:0]         req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [SRC_W-1:0]         rsp_rdata,
  output logic [NUM_LVL-1:0]       irq_o
);
  logic [NUM_LVL-1:0][SRC_W-1:0] mask_w;
  logic [NUM_LVL-1:0][SRC_W-1:0] stat_w;
  logic [NUM_LVL-1:0]            set_we;
  logic [NUM_LVL-1:0]            clr_we;
  logic [SRC_W-1:0]              wdata;

  imc_regbus #(
    .NUM_LVL (NUM_LVL),
    .DATA_W  (SRC_W),
    .ADDR_W  (ADDR_W)
  ) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid),
    .rsp_ready_i (rsp_ready),
    .rsp_rdata_o (rsp_rdata),
    .lvl_mask_i  (mask_w),
    .lvl_stat_i  (stat_w),
    .set_we_o    (set_we),
    .clr_we_o    (clr_we),
    .wdata_o     (wdata)
  );

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    imc_level #(.SRC_W(SRC_W)) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_lvl_i[l*SRC_W +: SRC_W]),
      .set_we_i (set_we[l]),
      .clr_we_i (clr_we[l]),
      .wdata_i  (wdata),
      .mask_o   (mask_w[l]),
      .stat_o   (stat_w[l]),
      .irq_o    (irq_o[l])
    );
  end

  AST_IRQ_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[0]) |-> ($past(clr_we[0]) || $past(src_lvl_i[SRC_W-1:0]) != $past(src_lvl_i[SRC_W-1:0], 2))); // R5
endmodule

// File: tb/intr_mask_ctrl_test.sv
module intr_mask_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] src;
  logic         req_valid, req_ready, req_write;
  logic [5:0]   req_addr;
  logic [31:0]  req_wdata;
  logic         rsp_valid, rsp_ready;
  logic [31:0]  rsp_rdata;
  logic [3:0]   irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  intr_mask_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_lvl_i(src),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_o(irq)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // driver: pushes the expected response into the scoreboard on acceptance
  task automatic xfer(input bit wr, input int lvl, input int slot, input logic [31:0] d,
                      input logic [31:0] e, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_addr  = 6'(lvl * 16 + slot * 4); req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(wr ? 32'h0 : e);
    tag_q.push_back(rq);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops one expectation per completed response beat
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected beat", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; src = '0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(irq == 4'b0, "R1 irq in reset", 32'(irq), 32'h0);
    check(rsp_valid == 1'b0, "R1 no beat in reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 32'h1);
    for (int l = 0; l < 4; l++) xfer(0, l, 2, 0, 32'hFFFF_FFFF, "R1 mask after reset");

    // R4 status capture with distinct patterns per level
    @(negedge clk);
    src[31:0] = 32'h0000_0100; src[63:32] = 32'hA5A5_0F0F;
    src[95:64] = 32'h8000_0001; src[127:96] = 32'h0;
    settle();
    xfer(0, 0, 3, 0, 32'h0000_0100, "R4 status level0");
    xfer(0, 1, 3, 0, 32'hA5A5_0F0F, "R4 status level1");
    xfer(0, 2, 3, 0, 32'h8000_0001, "R4 status level2");
    xfer(0, 3, 3, 0, 32'h0, "R4 status level3");
    settle();
    check(irq == 4'b0, "R1 all masked", 32'(irq), 32'h0);

    // R8 doorbell trap
    xfer(1, 0, 1, 32'h10, 0, "R8 clear 0x10 beat");
    settle();
    check(irq[0] == 1'b0, "R8 doorbell still masked", 32'(irq[0]), 32'h0);
    xfer(0, 0, 2, 0, 32'hFFFF_FFEF, "R8 mask after 0x10");
    xfer(1, 0, 1, 32'h100, 0, "R8 clear 0x100 beat");
    settle();
    check(irq[0] == 1'b1, "R8 doorbell unmasked", 32'(irq[0]), 32'h1);
    xfer(0, 0, 2, 0, 32'hFFFF_FEEF, "R3 mask after two clears");

    // R2 set re-masks only the named bit
    xfer(1, 0, 0, 32'h100, 0, "R2 set beat");
    settle();
    check(irq[0] == 1'b0, "R2 set masks doorbell", 32'(irq[0]), 32'h0);
    xfer(0, 0, 2, 0, 32'hFFFF_FFEF, "R2 mask after set");

    // R6 level isolation
    xfer(1, 2, 1, 32'h1, 0, "R6 clear level2 beat");
    settle();
    check(irq == 4'b0100, "R6 only level2 requests", 32'(irq), 32'h4);
    xfer(0, 1, 2, 0, 32'hFFFF_FFFF, "R6 level1 untouched");
    xfer(0, 3, 2, 0, 32'hFFFF_FFFF, "R6 level3 untouched");

    // R7 read-zero and ignored writes
    xfer(0, 2, 0, 0, 32'h0, "R7 set reads zero");
    xfer(0, 2, 1, 0, 32'h0, "R7 clear reads zero");
    xfer(1, 2, 2, 32'h0, 0, "R7 mask write beat");
    xfer(1, 2, 3, 32'h0, 0, "R7 status write beat");
    xfer(0, 2, 2, 0, 32'hFFFF_FFFE, "R7 mask unchanged");
    xfer(0, 2, 3, 0, 32'h8000_0001, "R7 status unchanged");
    settle();
    check(irq == 4'b0100, "R7 irq unchanged", 32'(irq), 32'h4);

    // R5 request follows sources through the mask
    xfer(1, 3, 1, 32'h0000_00F0, 0, "R5 clear level3 beat");
    settle();
    check(irq[3] == 1'b0, "R5 no pending source", 32'(irq[3]), 32'h0);
    @(negedge clk);
    src[127:96] = 32'h20;
    #1 check(irq[3] == 1'b0, "R4 one cycle of latency", 32'(irq[3]), 32'h0);
    @(negedge clk);
    check(irq[3] == 1'b1, "R5 unmasked source requests", 32'(irq[3]), 32'h1);
    src[127:96] = 32'h01;
    @(negedge clk);
    check(irq[3] == 1'b0, "R5 masked source silent", 32'(irq[3]), 32'h0);
    xfer(0, 3, 2, 0, 32'hFFFF_FF0F, "R3 zeros keep mask");
    xfer(1, 1, 1, 32'h0000_F000, 0, "R5 clear level1 beat");
    settle();
    check(irq[1] == 1'b0, "R5 no overlap level1", 32'(irq[1]), 32'h0);
    src[44] = 1'b1;
    @(negedge clk);
    check(irq[1] == 1'b1, "R5 overlap level1", 32'(irq[1]), 32'h1);

    // R9 back-pressure
    rsp_ready = 1'b0;
    xfer(0, 2, 3, 0, 32'h8000_0001, "R9 stalled read data");
    @(negedge clk);
    check(rsp_valid == 1'b1, "R9 beat waits", 32'(rsp_valid), 32'h1);
    check(req_ready == 1'b0, "R9 ready low in stall", 32'(req_ready), 32'h0);
    held = rsp_rdata;
    repeat (3) begin
      @(negedge clk);
      check(rsp_valid && rsp_rdata == held, "R9 beat held", rsp_rdata, held);
    end
    @(posedge clk);
    #1 rsp_ready = 1'b1;
    settle();
    check(exp_q.size() == 0, "R9 all beats returned", 32'(exp_q.size()), 32'h0);
    check(rsp_valid == 1'b0, "R9 beat released", 32'(rsp_valid), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule